// File: doc/BRIEF.md
# Column-Strobed Serial LED Matrix Refresher

This block keeps a four-character, 5x7 dot-matrix LED display lit by scanning its columns. The display holds a 28-bit serial-in/parallel-out row register and has one strobe input for each of its five columns. The refresher owns a small frame memory holding one 7-bit row pattern for each character and column. A simple write port fills it. For each column the block reads the four patterns for that column. It shifts them into the display as one 28-bit serial load, then lights that column for a programmable number of system clocks.

The shift clock is a divided version of the system clock. Each half period lasts `HALF_DIV` system clocks, which keeps the clock within the display's rate and pulse-width limits: 25 clocks at 250 MHz gives 100 ns halves and 5 MHz. Serial data changes with the rising shift-clock edge, and the display samples it on the falling edge. All strobes stay off while bits move. A separate active-low blanking output darkens the display on request and does not disturb the scan.

Top module: `led_col_refresher`

## Requirements
- R1: Each column load is 28 bits. The byte of character index 3 goes first and the byte of character index 0 goes last. Within a byte, bit 6 (row 7) goes first and bit 0 (row 1) goes last. A 1 bit lights the row.
- R2: `sdo` changes only together with a rising `sclk` edge, or while `sclk` is low between loads. It is stable at every falling `sclk` edge.
- R3: Every high phase of `sclk`, and every low phase inside a load, lasts exactly `HALF_DIV` system clocks. `sclk` rests low between loads.
- R4: `col_drv` is all zero while a load is in progress. At least one system clock with all strobes off separates a strobe's release from the next `sclk` edge.
- R5: At most one strobe bit is high at a time. After each load, only the strobe of the column just loaded is raised. Columns go 1 to 5 (`col_drv` bit 0 to bit 4) and then repeat.
- R6: A strobe stays high for `on_time` system clocks. The block samples `on_time` when the strobe rises, and a value of 0 gives one clock.
- R7: `blank_n` is low in the cycle after `blank_req` is high and high in the cycle after it is low. The scan continues unchanged while blanked.
- R8: A write with `wr_en` high stores `wr_rows` for character `wr_char` (0 to 3) and column `wr_col` (0 to 4). Writes are accepted during reset. A write that lands before the block fetches a column appears in the next load of that column.
- R9: During reset `sdo`, `sclk` and `col_drv` are 0 and `blank_n` is 0. The first load after reset is column 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Frame memory write strobe |
| wr_char | input | 2 | Character index of the write |
| wr_col | input | 3 | Column index of the write |
| wr_rows | input | 7 | Row pattern; bit 0 is row 1 |
| on_time | input | 16 | Strobe on-time in system clocks |
| blank_req | input | 1 | Request to darken the display |
| sdo | output | 1 | Serial row data to the display |
| sclk | output | 1 | Shift clock to the display |
| col_drv | output | 5 | Column strobes, bit 0 is column 1 |
| blank_n | output | 1 | Active-low blanking output |

## Verification
On every cycle, the assertions check that at most one strobe is high and that no strobe is high while the serializer is busy. They also check that data holds across each falling shift edge, that the shift clock only toggles at the end of a divider count, and that blanking follows the request one cycle later. Only the bench scenarios can show the rest. These are the bit order of each 28-bit load, the column sequence, the strobe width under different on-times including zero, and the exact half-period lengths. They also include a frame write made mid-scan and the point at which it becomes visible.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_START = 3'd1,
    ST_LOAD  = 3'd2,
    ST_ON    = 3'd3,
    ST_GAP   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/lmr_frame_mem.sv
module lmr_frame_mem #(
  parameter int DEPTH = 20,
  parameter int WIDTH = 7,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lmr_serializer.sv
module lmr_serializer #(
  parameter int W    = 28,
  parameter int HALF = 25,
  localparam int CW  = $clog2(HALF + 1),
  localparam int BW  = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] word,
  output logic         busy,
  output logic         done,
  output logic         sdo,
  output logic         sclk
);
  logic [W-1:0]  sreg;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      cnt    <= '0;
      bitcnt <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      sdo    <= 1'b0;
      sclk   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          sreg   <= word;
          sdo    <= word[W-1];
          sclk   <= 1'b1;
          cnt    <= '0;
          bitcnt <= '0;
        end
      end else if (cnt == CW'(HALF - 1)) begin
        cnt <= '0;
        if (sclk) begin
          sclk <= 1'b0;
        end else if (bitcnt == BW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          sdo  <= 1'b0;
        end else begin
          sclk   <= 1'b1;
          sreg   <= {sreg[W-2:0], 1'b0};
          sdo    <= sreg[W-2];
          bitcnt <= bitcnt + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: data must hold across the capture edge
  p_sdo_stable_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> $stable(sdo));

  // R3: the shift clock only toggles when the divider count wraps
  p_sclk_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> $stable(sclk));
endmodule

// File: rtl/lmr_sequencer.sv
module lmr_sequencer
  import lmr_pkg::*;
#(
  parameter int CHARS = 4,
  parameter int ROWS  = 7,
  parameter int COLS  = 5,
  parameter int ON_W  = 16,
  localparam int W      = CHARS * ROWS,
  localparam int DEPTH  = CHARS * COLS,
  localparam int AW     = $clog2(DEPTH),
  localparam int COL_W  = $clog2(COLS),
  localparam int CHAR_W = $clog2(CHARS),
  localparam int FC_W   = $clog2(CHARS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ON_W-1:0] on_time,
  output logic [AW-1:0]   rd_addr,
  input  logic [ROWS-1:0] rd_data,
  output logic            ser_start,
  output logic [W-1:0]    ser_word,
  input  logic            ser_done,
  output logic [COLS-1:0] col_drv
);
  seq_state_t        state;
  logic [COL_W-1:0]  col;
  logic [FC_W-1:0]   fcnt;
  logic              rd_pend;
  logic [CHAR_W-1:0] ridx;
  logic [W-1:0]      stage;
  logic [ON_W-1:0]   on_cnt;
  logic [ON_W-1:0]   on_len;

  always_comb begin
    rd_addr   = AW'(int'(col) * CHARS + int'(fcnt));
    ser_start = (state == ST_START);
    ser_word  = stage;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FETCH;
      col     <= '0;
      fcnt    <= '0;
      rd_pend <= 1'b0;
      ridx    <= '0;
      stage   <= '0;
      on_cnt  <= '0;
      on_len  <= '0;
      col_drv <= '0;
    end else begin
      rd_pend <= (state == ST_FETCH) && (fcnt < FC_W'(CHARS));
      ridx    <= CHAR_W'(fcnt);
      if (rd_pend) stage[int'(ridx)*ROWS +: ROWS] <= rd_data;
      unique case (state)
        ST_FETCH: begin
          if (fcnt < FC_W'(CHARS)) fcnt <= fcnt + 1'b1;
          else                     state <= ST_START;
        end
        ST_START: state <= ST_LOAD;
        ST_LOAD: begin
          if (ser_done) begin
            state   <= ST_ON;
            on_cnt  <= '0;
            on_len  <= (on_time == '0) ? ON_W'(1) : on_time;
            col_drv <= COLS'(1) << col;
          end
        end
        ST_ON: begin
          if (on_cnt == on_len - 1'b1) begin
            col_drv <= '0;
            state   <= ST_GAP;
          end else begin
            on_cnt <= on_cnt + 1'b1;
          end
        end
        ST_GAP: begin
          col   <= (col == COL_W'(COLS - 1)) ? '0 : col + 1'b1;
          fcnt  <= '0;
          state <= ST_FETCH;
        end
        default: state <= ST_FETCH;
      endcase
    end
  end

  // R5: never more than one column lit
  p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_drv));

  // R6: a strobe never rises outside the on phase
  p_strobe_in_on_r6: assert property (@(posedge clk) disable iff (rst)
    (col_drv != '0) |-> (state == ST_ON));
endmodule

// File: rtl/led_col_refresher.sv
module led_col_refresher #(
  parameter int CHARS    = 4,
  parameter int ROWS     = 7,
  parameter int COLS     = 5,
  parameter int ON_W     = 16,
  parameter int HALF_DIV = 25
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(CHARS)-1:0] wr_char,
  input  logic [$clog2(COLS)-1:0]  wr_col,
  input  logic [ROWS-1:0]          wr_rows,
  input  logic [ON_W-1:0]          on_time,
  input  logic                     blank_req,
  output logic                     sdo,
  output logic                     sclk,
  output logic [COLS-1:0]          col_drv,
  output logic                     blank_n
);
  localparam int W     = CHARS * ROWS;
  localparam int DEPTH = CHARS * COLS;
  localparam int AW    = $clog2(DEPTH);

  logic [AW-1:0]   waddr;
  logic            we;
  logic [AW-1:0]   rd_addr;
  logic [ROWS-1:0] rd_data;
  logic            ser_start;
  logic [W-1:0]    ser_word;
  logic            ser_done;
  logic            ser_busy;

  always_comb begin
    waddr = AW'(int'(wr_col) * CHARS + int'(wr_char));
    we    = wr_en && (int'(wr_col) < COLS);
  end

  lmr_frame_mem #(.DEPTH(DEPTH), .WIDTH(ROWS)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wr_rows),
    .raddr(rd_addr), .rdata(rd_data)
  );

  lmr_sequencer #(.CHARS(CHARS), .ROWS(ROWS), .COLS(COLS), .ON_W(ON_W)) u_seq (
    .clk(clk), .rst(rst), .on_time(on_time), .rd_addr(rd_addr),
    .rd_data(rd_data), .ser_start(ser_start), .ser_word(ser_word),
    .ser_done(ser_done), .col_drv(col_drv)
  );

  lmr_serializer #(.W(W), .HALF(HALF_DIV)) u_ser (
    .clk(clk), .rst(rst), .start(ser_start), .word(ser_word),
    .busy(ser_busy), .done(ser_done), .sdo(sdo), .sclk(sclk)
  );

  always_ff @(posedge clk) begin
    if (rst) blank_n <= 1'b0;
    else     blank_n <= ~blank_req;
  end

  // R4: strobes stay dark for the whole serial load
  p_no_strobe_shift_r4: assert property (@(posedge clk) disable iff (rst)
    ser_busy |-> (col_drv == '0));

  // R7: blanking follows the request one cycle later
  p_blank_on_r7: assert property (@(posedge clk) disable iff (rst)
    blank_req |=> !blank_n);
  p_blank_off_r7: assert property (@(posedge clk) disable iff (rst)
    !blank_req |=> blank_n);
endmodule

// File: tb/led_col_refresher_test.sv
module led_col_refresher_test;
  localparam int HALF = 25;

  typedef struct packed {
    logic [27:0] word;
    logic [2:0]  col;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_char;
  logic [2:0]  wr_col;
  logic [6:0]  wr_rows;
  logic [15:0] on_time;
  logic        blank_req;
  logic        sdo, sclk, blank_n;
  logic [4:0]  col_drv;

  led_col_refresher #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char), .wr_col(wr_col),
    .wr_rows(wr_rows), .on_time(on_time), .blank_req(blank_req),
    .sdo(sdo), .sclk(sclk), .col_drv(col_drv), .blank_n(blank_n)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  exp_t q[$];
  logic [6:0] fm [5][4];
  int cur_w = 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_col(input int c);
    exp_t e;
    e.word = {fm[c][3], fm[c][2], fm[c][1], fm[c][0]};
    e.col  = 3'(c);
    q.push_back(e);
  endtask

  task automatic wr(input int c, input int ch, input logic [6:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_col = 3'(c); wr_char = 2'(ch); wr_rows = v;
    fm[c][ch] = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor / scoreboard
  logic        prev_sclk, prev_sdo;
  logic [4:0]  prev_col, seen_col;
  logic [27:0] word;
  int nbits, run_len, on_len, col_done;
  bit len_bad, strobe_bad, sdo_bad, have_exp;
  exp_t cur;

  always @(negedge clk) begin
    if (rst) begin
      prev_sclk = 0; prev_sdo = 0; prev_col = 0; seen_col = 0; word = 0;
      nbits = 0; run_len = 0; on_len = 0; col_done = 0;
      len_bad = 0; strobe_bad = 0; sdo_bad = 0; have_exp = 0;
    end else begin
      if (sclk && prev_sclk && sdo !== prev_sdo) sdo_bad = 1;
      if (sclk !== prev_sclk) begin
        if (!(sclk && nbits == 0) && run_len != HALF) len_bad = 1;
        if (col_drv != 0 || prev_col != 0) strobe_bad = 1;
        run_len = 1;
        if (!sclk) begin
          word = {word[26:0], sdo};
          nbits++;
          if (nbits == 28) begin
            if (q.size() == 0) begin
              chk(0, "R5 unexpected load", 32'(word), 0);
              have_exp = 0;
            end else begin
              cur = q.pop_front();
              chk(word == cur.word, "R1/R8 load word", 32'(word), 32'(cur.word));
              have_exp = 1;
            end
            chk(!len_bad, "R3 half period", 32'(len_bad), 0);
            chk(!strobe_bad, "R4 strobe during load", 32'(strobe_bad), 0);
            chk(!sdo_bad, "R2 data change while high", 32'(sdo_bad), 0);
            nbits = 0; len_bad = 0; strobe_bad = 0; sdo_bad = 0;
          end
        end
      end else begin
        run_len++;
      end
      if (col_drv != 0) begin
        if (on_len == 0) seen_col = col_drv;
        else if (col_drv != seen_col) strobe_bad = 1;
        on_len++;
      end else if (prev_col != 0) begin
        chk(have_exp && seen_col == (5'd1 << cur.col), "R5 column strobe",
            32'(seen_col), 32'(5'd1 << cur.col));
        chk(on_len == cur_w, "R6 strobe width", 32'(on_len), 32'(cur_w));
        col_done++;
        on_len = 0;
        have_exp = 0;
      end
      prev_sclk = sclk; prev_sdo = sdo; prev_col = col_drv;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    q.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; wr_en = 0; wr_char = 0; wr_col = 0; wr_rows = 0;
    on_time = 16'd3; blank_req = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(sdo == 0 && sclk == 0, "R9 reset serial pins", {sdo, sclk}, 0);
    chk(col_drv == 0, "R9 reset strobes", 32'(col_drv), 0);
    chk(blank_n == 0, "R9 reset blank", 32'(blank_n), 0);

    // scenario A: mixed patterns, written during reset (R8), two full scans
    for (int c = 0; c < 5; c++)
      for (int k = 0; k < 4; k++) wr(c, k, 7'((c * 29 + k * 13 + 5) % 128));
    cur_w = 3;
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 5; c++) push_col(c);
    @(negedge clk); rst = 1'b0;
    wait (col_done == 2);
    @(negedge clk); blank_req = 1'b1;
    @(negedge clk);
    chk(blank_n == 0, "R7 blank asserted", 32'(blank_n), 0);
    repeat (200) @(negedge clk);
    chk(blank_n == 0, "R7 blank held", 32'(blank_n), 0);
    blank_req = 1'b0;
    @(negedge clk);
    chk(blank_n == 1, "R7 blank released", 32'(blank_n), 1);
    wait (col_done == 10);
    chk(q.size() == 0, "R5 scan A complete", q.size(), 0);

    // scenario B: single-row patterns for bit order, on_time 0 -> width 1 (R1, R6)
    do_reset();
    for (int c = 0; c < 5; c++)
      for (int k = 0; k < 4; k++) wr(c, k, ((k + c) & 1) ? 7'h40 : 7'h01);
    on_time = 16'd0; cur_w = 1;
    for (int c = 0; c < 5; c++) push_col(c);
    @(negedge clk); rst = 1'b0;
    wait (col_done == 5);
    chk(q.size() == 0, "R6 scan B complete", q.size(), 0);

    // scenario C: write mid-scan, visible at next fetch of the column (R8)
    do_reset();
    for (int c = 0; c < 5; c++)
      for (int k = 0; k < 4; k++) wr(c, k, 7'(c * 20 + k + 3));
    on_time = 16'd2; cur_w = 2;
    for (int c = 0; c < 3; c++) push_col(c);
    @(negedge clk); rst = 1'b0;
    wait (col_drv == 5'b00100);
    @(negedge clk);
    wr_en = 1'b1; wr_col = 3'd2; wr_char = 2'd1; wr_rows = 7'h7F; fm[2][1] = 7'h7F;
    @(negedge clk);
    wr_col = 3'd3; wr_char = 2'd3; wr_rows = 7'h2A; fm[3][3] = 7'h2A;
    @(negedge clk);
    wr_en = 1'b0;
    push_col(3); push_col(4); push_col(0); push_col(1); push_col(2);
    wait (col_done == 8);
    chk(q.size() == 0, "R8 scan C complete", q.size(), 0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end
endmodule